// File: doc/BRIEF.md
# Green Mode Burst Controller

This block decides, once per PWM master-clock period, whether the power-factor stage may run and whether the next PWM pulse may be issued. It sees two digitized voltages as unsigned millivolt codes: the PWM duty-control level (`vdc_mv`) and the PFC feedback level (`vfb_mv`). It acts only on cycles where `tick` is high, so every gating change lines up with the PWM clock.

At light load the block leaves normal operation and turns the PFC off. PWM pulses are then gated against a higher threshold, which produces synchronous pulse skipping. When the bus sags, the feedback falls below a low level. The PFC then restarts with a soft-start request, and the block counts as having left the low-power mode. While the PFC recharges, PWM pulses run freely and the duty level is judged against the lower entry threshold. When the bus is back at its upper level, the block returns to skipping only if the duty level is still below that entry threshold.

The four thresholds sit in writable registers. They reset to 1300, 1580, 2250 and 2500 mV.

Top module: `gm_ctrl`

## Requirements
- R1: After reset `pfc_en`=1, `pwm_en`=1, `green`=0 and `ss_req`=0. The thresholds reset to enter=1300, gate=1580, restart=2250 and full=2500 mV.
- R2: State and outputs change only on a clock edge where `tick`=1. On other edges `pfc_en`, `pwm_en` and `green` hold, and `ss_req` is 0.
- R3: In normal mode, a tick with vdc < enter and vfb >= full moves the block to skip mode. That tick gives `pfc_en`=0 and `green`=1, and `pwm_en` becomes (vdc >= gate).
- R4: In normal mode, a tick that does not meet the R3 condition leaves `pfc_en`=1, `pwm_en`=1 and `green`=0. This covers vdc < enter while vfb is still below full, which is a recharge that has not finished.
- R5: In skip mode, a tick with vfb >= restart sets `pwm_en` to (vdc >= gate). A value equal to gate allows the pulse.
- R6: In skip mode, a tick with vfb < restart returns the block to normal mode with `pfc_en`=1, `pwm_en`=1 and `green`=0.
- R7: In skip mode, a tick with vfb >= restart keeps `pfc_en`=0 and `green`=1. A vfb equal to restart does not restart the PFC.
- R8: `ss_req` is high for exactly one clock, right after the tick edge where `pfc_en` goes from 0 to 1. It is never high otherwise.
- R9: A recharge ends only when vfb >= full and vdc < enter on the same tick. If vdc >= enter at that tick, the block stays in normal mode with the PFC on.
- R10: A write with `cfg_wr`=1 loads `cfg_data` into a threshold. The address selects the threshold: 0 = enter, 1 = gate, 2 = restart, 3 = full. Every tick after the write edge uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | PWM master-clock period marker; decisions are taken when high |
| vdc_mv | input | 12 | Duty-control voltage, mV |
| vfb_mv | input | 12 | PFC feedback voltage, mV |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_addr | input | 2 | Threshold select: 0 enter, 1 gate, 2 restart, 3 full |
| cfg_data | input | 12 | Threshold value to write, mV |
| pfc_en | output | 1 | PFC stage allowed to run |
| pwm_en | output | 1 | Next PWM pulse allowed |
| green | output | 1 | Low-power skip mode active |
| ss_req | output | 1 | One-clock soft-start request on each PFC turn-on |

## Verification
The hardest condition to reach is the end of a recharge burst. It needs the feedback to reach the full level on the same tick where the duty level sits just below the entry threshold, and it must be preceded by a skip period and a restart. The bench drives a pseudo-random walk where every sample lands one millivolt below, on, or above one of the thresholds. A bench-side model of the mode follows every tick. The walk therefore passes through entry, skipping, restart and burst-end many times, and it hits each equality boundary. The walk is run again after all four thresholds are reprogrammed, and idle clocks between ticks check that nothing moves.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic {GM_NORMAL = 1'b0, GM_SKIP = 1'b1} gm_mode_e;

  localparam int GM_NUM_THR  = 4;
  localparam int GM_IDX_ENTER   = 0;
  localparam int GM_IDX_GATE    = 1;
  localparam int GM_IDX_RESTART = 2;
  localparam int GM_IDX_FULL    = 3;

  // Unsigned level comparisons on millivolt codes (zero-extended to 16 bits).
  function automatic logic mv_below(input logic [15:0] level, input logic [15:0] thr);
    return level < thr;
  endfunction

  function automatic logic mv_at_or_above(input logic [15:0] level, input logic [15:0] thr);
    return !(level < thr);
  endfunction
endpackage

// File: rtl/gm_thresh_regs.sv
module gm_thresh_regs #(
  parameter int MV_W = 12,
  parameter int NUM  = 4,
  parameter logic [NUM*MV_W-1:0] RESET_VALS = '0,
  localparam int ADDR_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MV_W-1:0]     data,
  output logic [NUM*MV_W-1:0] thr_flat
);
  for (genvar i = 0; i < NUM; i++) begin : g_thr
    logic [MV_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             val <= RESET_VALS[i*MV_W +: MV_W];
      else if (wr && addr == ADDR_W'(i))      val <= data;
    end
    assign thr_flat[i*MV_W +: MV_W] = val;
  end
endmodule

// File: rtl/gm_compare.sv
module gm_compare
  import gm_pkg::*;
#(
  parameter int MV_W = 12
) (
  input  logic [MV_W-1:0]            vdc_mv,
  input  logic [MV_W-1:0]            vfb_mv,
  input  logic [GM_NUM_THR*MV_W-1:0] thr_flat,
  output logic                       vdc_lt_enter,
  output logic                       vdc_ge_gate,
  output logic                       vfb_lt_restart,
  output logic                       vfb_ge_full
);
  logic [MV_W-1:0] t_enter, t_gate, t_restart, t_full;
  assign t_enter   = thr_flat[GM_IDX_ENTER*MV_W   +: MV_W];
  assign t_gate    = thr_flat[GM_IDX_GATE*MV_W    +: MV_W];
  assign t_restart = thr_flat[GM_IDX_RESTART*MV_W +: MV_W];
  assign t_full    = thr_flat[GM_IDX_FULL*MV_W    +: MV_W];

  assign vdc_lt_enter   = mv_below(16'(vdc_mv), 16'(t_enter));
  assign vdc_ge_gate    = mv_at_or_above(16'(vdc_mv), 16'(t_gate));
  assign vfb_lt_restart = mv_below(16'(vfb_mv), 16'(t_restart));
  assign vfb_ge_full    = mv_at_or_above(16'(vfb_mv), 16'(t_full));
endmodule

// File: rtl/gm_fsm.sv
module gm_fsm
  import gm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vdc_lt_enter,
  input  logic vdc_ge_gate,
  input  logic vfb_lt_restart,
  input  logic vfb_ge_full,
  output logic mode_skip,
  output logic evt_enter,
  output logic evt_restart,
  output logic pfc_en,
  output logic pwm_en,
  output logic green,
  output logic ss_req
);
  gm_mode_e mode;

  assign mode_skip   = (mode == GM_SKIP);
  assign evt_enter   = tick && !mode_skip && vdc_lt_enter && vfb_ge_full;
  assign evt_restart = tick && mode_skip && vfb_lt_restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= GM_NORMAL;
      pfc_en <= 1'b1;
      pwm_en <= 1'b1;
      green  <= 1'b0;
      ss_req <= 1'b0;
    end else begin
      ss_req <= 1'b0;
      if (tick) begin
        unique case (mode)
          GM_NORMAL: begin
            if (evt_enter) begin
              mode   <= GM_SKIP;
              pfc_en <= 1'b0;
              green  <= 1'b1;
              pwm_en <= vdc_ge_gate;
            end else begin
              pfc_en <= 1'b1;
              pwm_en <= 1'b1;
              green  <= 1'b0;
            end
          end
          GM_SKIP: begin
            if (evt_restart) begin
              mode   <= GM_NORMAL;
              pfc_en <= 1'b1;
              pwm_en <= 1'b1;
              green  <= 1'b0;
              ss_req <= 1'b1;
            end else begin
              pwm_en <= vdc_ge_gate;
            end
          end
          default: mode <= GM_NORMAL;
        endcase
      end
    end
  end
endmodule

// File: rtl/gm_ctrl.sv
module gm_ctrl
  import gm_pkg::*;
#(
  parameter int MV_W = 12,
  parameter logic [MV_W-1:0] RST_ENTER   = 12'd1300,
  parameter logic [MV_W-1:0] RST_GATE    = 12'd1580,
  parameter logic [MV_W-1:0] RST_RESTART = 12'd2250,
  parameter logic [MV_W-1:0] RST_FULL    = 12'd2500,
  localparam int ADDR_W = $clog2(GM_NUM_THR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MV_W-1:0]   vdc_mv,
  input  logic [MV_W-1:0]   vfb_mv,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MV_W-1:0]   cfg_data,
  output logic              pfc_en,
  output logic              pwm_en,
  output logic              green,
  output logic              ss_req
);
  localparam logic [GM_NUM_THR*MV_W-1:0] RST_VALS = {RST_FULL, RST_RESTART, RST_GATE, RST_ENTER};

  logic [GM_NUM_THR*MV_W-1:0] thr_flat;
  logic vdc_lt_enter, vdc_ge_gate, vfb_lt_restart, vfb_ge_full;
  logic mode_skip, evt_enter, evt_restart;

  gm_thresh_regs #(.MV_W(MV_W), .NUM(GM_NUM_THR), .RESET_VALS(RST_VALS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .data(cfg_data),
    .thr_flat(thr_flat)
  );

  gm_compare #(.MV_W(MV_W)) u_cmp (
    .vdc_mv(vdc_mv), .vfb_mv(vfb_mv), .thr_flat(thr_flat),
    .vdc_lt_enter(vdc_lt_enter), .vdc_ge_gate(vdc_ge_gate),
    .vfb_lt_restart(vfb_lt_restart), .vfb_ge_full(vfb_ge_full)
  );

  gm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .vdc_lt_enter(vdc_lt_enter), .vdc_ge_gate(vdc_ge_gate),
    .vfb_lt_restart(vfb_lt_restart), .vfb_ge_full(vfb_ge_full),
    .mode_skip(mode_skip), .evt_enter(evt_enter), .evt_restart(evt_restart),
    .pfc_en(pfc_en), .pwm_en(pwm_en), .green(green), .ss_req(ss_req)
  );
endmodule

// File: rtl/gm_ctrl_chk.sv
module gm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mode_skip,
  input logic evt_enter,
  input logic evt_restart,
  input logic vdc_ge_gate,
  input logic pfc_en,
  input logic pwm_en,
  input logic green,
  input logic ss_req
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(tick) |-> $stable(pfc_en) && $stable(pwm_en) && $stable(green) && !ss_req);

  assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(evt_enter) |-> green && !pfc_en);

  assert_stay_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(tick && !mode_skip && !evt_enter) |-> pfc_en && pwm_en && !green);

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(tick && mode_skip && !evt_restart) |-> pwm_en == $past(vdc_ge_gate));

  assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(evt_restart) |-> pfc_en && pwm_en && !green);

  assert_stay_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(tick && mode_skip && !evt_restart) |-> !pfc_en && green);

  assert_softstart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(pfc_en) |-> ss_req);

  assert_softstart_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && ss_req |-> pfc_en && $past(!pfc_en));
endmodule

bind gm_ctrl gm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode_skip(mode_skip),
  .evt_enter(evt_enter), .evt_restart(evt_restart), .vdc_ge_gate(vdc_ge_gate),
  .pfc_en(pfc_en), .pwm_en(pwm_en), .green(green), .ss_req(ss_req)
);

// File: tb/tb_gm_ctrl.sv
module tb_gm_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [11:0] vdc_mv = '0, vfb_mv = '0, cfg_data = '0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic pfc_en, pwm_en, green, ss_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of thresholds and mode
  int t_enter = 1300, t_gate = 1580, t_restart = 2250, t_full = 2500;
  bit m_skip = 0, e_pfc = 1, e_pwm = 1, e_green = 0;

  always #2.5 clk = ~clk;

  gm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vdc_mv(vdc_mv), .vfb_mv(vfb_mv),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .pfc_en(pfc_en), .pwm_en(pwm_en), .green(green), .ss_req(ss_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input bit exp_ss);
    chk({tag, " pfc_en"}, pfc_en, e_pfc);
    chk({tag, " pwm_en"}, pwm_en, e_pwm);
    chk({tag, " green"},  green,  e_green);
    chk({tag, " ss_req"}, ss_req, exp_ss);
  endtask

  // one tick with model update, then checks one clock later at the negedge
  task automatic step(input int vdc, input int vfb, input string suffix);
    string tag;
    bit exp_ss = 0;
    @(negedge clk);
    vdc_mv = 12'(vdc); vfb_mv = 12'(vfb); tick = 1'b1;
    if (!m_skip) begin
      if (vdc < t_enter && vfb >= t_full) begin
        tag = "R3"; m_skip = 1; e_pfc = 0; e_green = 1; e_pwm = (vdc >= t_gate);
      end else begin
        tag = (vdc < t_enter) ? "R9" : "R4"; e_pfc = 1; e_pwm = 1; e_green = 0;
      end
    end else begin
      if (vfb < t_restart) begin
        tag = "R6/R8"; m_skip = 0; e_pfc = 1; e_pwm = 1; e_green = 0; exp_ss = 1;
      end else begin
        tag = "R5/R7"; e_pwm = (vdc >= t_gate);
      end
    end
    @(negedge clk);
    tick = 1'b0;
    chk_all({tag, suffix}, exp_ss);
  endtask

  // idle clocks with scrambled inputs: nothing may change
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      vdc_mv = 12'(i * 977); vfb_mv = 12'(i * 1231);
      @(negedge clk);
      chk_all("R2 hold", 1'b0);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input int v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_data = 12'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic int pick(input int base_a, input int base_b, input int r);
    int base = (r[0]) ? base_b : base_a;
    return base + (((r >> 1) % 3) - 1);
  endfunction

  task automatic walk(input int n, input int seed, input string suffix);
    int lf = seed;
    for (int i = 0; i < n; i++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      step(pick(t_enter, t_gate, lf >> 4), pick(t_restart, t_full, lf >> 12), suffix);
      if ((lf >> 20) % 8 == 0) idle(2);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 1'b0);
    rst_n = 1'b1;
    idle(3);
    // directed: equality edges at reset thresholds (R1 values)
    step(1300, 2500, " R1 enter edge stays normal");   // vdc==enter -> R4
    step(1299, 2499, " R1 full edge stays normal");    // vfb<full -> R9
    step(1299, 2500, " R1 enter");                     // R3
    step(1580, 2250, " R1 gate equal");                // R5 pulse, R7 no restart
    step(1579, 2250, " R1 gate below");                // R5 skip
    step(1579, 2249, " R1 restart");                   // R6, R8
    idle(2);
    walk(3000, 7, "");
    // R10: reprogram thresholds, then enter skip and check new levels
    cfg(2'd0, 900); t_enter = 900;
    cfg(2'd1, 1100); t_gate = 1100;
    cfg(2'd2, 2000); t_restart = 2000;
    cfg(2'd3, 2300); t_full = 2300;
    idle(2);
    if (m_skip) step(1000, 1999, " R10 leave");
    step(1000, 2300, " R10 old enter level now above");
    step(899, 2300, " R10 new enter");
    step(1100, 2100, " R10 new gate");
    step(1099, 2000, " R10 new restart edge");
    step(1099, 1999, " R10 new restart");
    walk(3000, 99, " R10");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule